// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block turns a 32-bit request address into a routing decision. It holds a small set of programmable windows. Each window has an enable, a two-bit access permission, a base address with an 8-bit target code, and a size mask. For every valid request it reports whether an enabled window matched, which one, its target code, its permission bits and, for memory targets, an active-low one-hot chip select. Requests that match nothing raise a miss.

Software programs the windows through a single-cycle register port. It can snapshot the whole window set into shadow storage and later put it back in one cycle, so that boot code can borrow the windows and then hand them back unchanged. A separate address-override register can be written, read back and cleared. It does not take part in decoding.

Typical programming packs the enabled memory chip selects into consecutive slots from slot 0, with target codes 0x0E, 0x0D, 0x0B and 0x07 for chip selects 0 to 3. An on-chip SRAM window with code 0x1E goes in the slot after the last memory window.

Top module: `addrwin_decoder`

## Requirements
- R1: Synchronous active-low reset clears every register: all windows are disabled, the override is zero, and a valid request after reset gives a miss.
- R2: The control word is at register address 0x00. Bit i enables window i and bits [16+2i+1:16+2i] hold window i's permission, which is reported as `rsp_perm` on a hit. All other bits read as zero.
- R3: The base register of window i is at 0x08+i and holds the address in [31:16] and the target code in [15:8], with [7:0] reading zero. The mask register is at 0x10+i and holds the mask in [31:16], with [15:0] reading zero. Addresses for windows at or above NUM_WIN, and all other unused addresses, ignore writes and read zero.
- R4: Window i matches when it is enabled and `(addr[31:16] ^ base[31:16]) & ~mask[31:16]` is zero. Mask 0x03FF therefore spans 64 MB and mask 0x0FFF spans 256 MB.
- R5: When several windows match, the lowest-numbered one wins and its index is reported on `rsp_win`.
- R6: A valid request with no matching window raises `rsp_miss` and reports window 0, target code 0, permission 0 and `rsp_cs_n` = 4'hF. `rsp_hit` and `rsp_miss` are never high together.
- R7: On a hit whose target code has [7:4] = 0 and exactly one zero bit in [3:0], `rsp_cs_n` equals code[3:0]. Otherwise, including the SRAM code 0x1E, it is 4'hF.
- R8: Lookup results are registered: they appear one cycle after the request. A cycle with `req_valid` low gives `rsp_hit` = `rsp_miss` = 0 in the next cycle.
- R9: `snap_save` copies the control word, the bases and the masks into shadow storage, using the values from before any write in that same cycle. `snap_restore` copies the shadow back in one cycle and blocks every register write in that cycle.
- R10: The override register is at 0x01. It stores a full 32-bit value, is cleared by writing zero, and never changes a lookup result.
- R11: A register write takes effect for lookups in the next cycle. A request in the same cycle as a write is decoded with the old values, and `cfg_rdata` shows the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| snap_save | input | 1 | Copy window registers to shadow |
| snap_restore | input | 1 | Copy shadow back to window registers |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Lookup address |
| rsp_hit | output | 1 | Registered: an enabled window matched |
| rsp_miss | output | 1 | Registered: valid request matched nothing |
| rsp_win | output | IDX_W (3) | Registered winning window index |
| rsp_attr | output | 8 | Registered target code |
| rsp_perm | output | 2 | Registered access permission |
| rsp_cs_n | output | 4 | Registered active-low one-hot chip select |

## Verification
Lookup results are due exactly one clock edge after the request. Register state is visible on `cfg_rdata` right after the edge that writes it. The bench's reference model applies each edge's stimulus at the posedge, first deriving the expected response from the pre-write state and only then applying the writes, the save and the restore. It compares every output at the following falling edge, and drives new stimulus 1 ns after that edge. This ordering also covers the case of a write and a request in the same cycle, because the model decodes that request with the old register values.

// File: rtl/addrwin_pkg.sv
// Shared constants for the address window decoder.
// Assumes a 5-bit register address split into a 2-bit group and a 3-bit select.
package addrwin_pkg;
    localparam int CFG_AW = 5;
    localparam logic [1:0] GRP_MISC = 2'd0;
    localparam logic [1:0] GRP_BASE = 2'd1;
    localparam logic [1:0] GRP_MASK = 2'd2;
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_OVRD = 3'd1;
    localparam int PERM_LSB = 16;
endpackage

// File: rtl/addrwin_regfile.sv
// Window register file with shadow save/restore and an override register.
// Assumes NUM_WIN <= 8, so the permission fields fit in bits [31:16].
module addrwin_regfile
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [CFG_AW-1:0]        addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic                     save,
    input  logic                     restore,
    output logic [NUM_WIN-1:0]       win_en,
    output logic [NUM_WIN-1:0][1:0]  win_perm,
    output logic [NUM_WIN-1:0][15:0] win_base,
    output logic [NUM_WIN-1:0][7:0]  win_attr,
    output logic [NUM_WIN-1:0][15:0] win_mask
);
    logic [1:0] grp;
    logic [2:0] sel;
    logic [31:0] ovrd_q;
    logic [NUM_WIN-1:0]       sh_en;
    logic [NUM_WIN-1:0][1:0]  sh_perm;
    logic [NUM_WIN-1:0][15:0] sh_base;
    logic [NUM_WIN-1:0][7:0]  sh_attr;
    logic [NUM_WIN-1:0][15:0] sh_mask;

    assign grp = addr[4:3];
    assign sel = addr[2:0];

    // Live registers: restore has priority over writes, and save takes pre-write values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en <= '0; win_perm <= '0; win_base <= '0; win_attr <= '0; win_mask <= '0;
            sh_en <= '0; sh_perm <= '0; sh_base <= '0; sh_attr <= '0; sh_mask <= '0;
            ovrd_q <= '0;
        end else if (restore) begin
            win_en <= sh_en; win_perm <= sh_perm; win_base <= sh_base;
            win_attr <= sh_attr; win_mask <= sh_mask;
        end else begin
            if (save) begin
                sh_en <= win_en; sh_perm <= win_perm; sh_base <= win_base;
                sh_attr <= win_attr; sh_mask <= win_mask;
            end
            if (we && grp == GRP_MISC && sel == SEL_OVRD)
                ovrd_q <= wdata;
            for (int i = 0; i < NUM_WIN; i++) begin
                if (we && grp == GRP_MISC && sel == SEL_CTRL) begin
                    win_en[i]   <= wdata[i];
                    win_perm[i] <= wdata[PERM_LSB+2*i +: 2];
                end
                if (we && grp == GRP_BASE && sel == 3'(i)) begin
                    win_base[i] <= wdata[31:16];
                    win_attr[i] <= wdata[15:8];
                end
                if (we && grp == GRP_MASK && sel == 3'(i))
                    win_mask[i] <= wdata[31:16];
            end
        end
    end

    // Read mux: unimplemented fields and addresses return zero.
    always_comb begin
        rdata = '0;
        case (grp)
            GRP_MISC: begin
                if (sel == SEL_CTRL) begin
                    for (int i = 0; i < NUM_WIN; i++) begin
                        rdata[i] = win_en[i];
                        rdata[PERM_LSB+2*i +: 2] = win_perm[i];
                    end
                end else if (sel == SEL_OVRD) begin
                    rdata = ovrd_q;
                end
            end
            GRP_BASE: if (int'(sel) < NUM_WIN) rdata = {win_base[sel], win_attr[sel], 8'h00};
            GRP_MASK: if (int'(sel) < NUM_WIN) rdata = {win_mask[sel], 16'h0000};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/addrwin_match.sv
// Per-window address comparators; one match bit per window.
// Assumes masks mark don't-care address bits with ones.
module addrwin_match #(
    parameter int NUM_WIN = 5
) (
    input  logic [31:0]              addr,
    input  logic [NUM_WIN-1:0]       win_en,
    input  logic [NUM_WIN-1:0][15:0] win_base,
    input  logic [NUM_WIN-1:0][15:0] win_mask,
    output logic [NUM_WIN-1:0]       hit_vec
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        // Enabled window whose unmasked upper address bits equal the base.
        assign hit_vec[i] = win_en[i] &&
            (((addr[31:16] ^ win_base[i]) & ~win_mask[i]) == 16'h0000);
    end
endmodule

// File: rtl/addrwin_select.sv
// Lowest-index priority pick and registered response, with chip-select decode.
// Assumes hit_vec and the window fields are stable for the cycle of the request.
module addrwin_select #(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [NUM_WIN-1:0]       hit_vec,
    input  logic [NUM_WIN-1:0][1:0]  win_perm,
    input  logic [NUM_WIN-1:0][7:0]  win_attr,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic [IDX_W-1:0]         rsp_win,
    output logic [7:0]               rsp_attr,
    output logic [1:0]               rsp_perm,
    output logic [3:0]               rsp_cs_n
);
    logic             any_hit;
    logic [IDX_W-1:0] pick;
    logic [7:0]       attr_pick;
    logic             cs_ok;

    // Priority encoder: scan downward so the lowest matching index is left last.
    always_comb begin
        any_hit = 1'b0;
        pick    = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                pick    = IDX_W'(i);
            end
        end
    end

    assign attr_pick = win_attr[pick];
    // Chip select only for a memory code: zero upper nibble and one zero bit below.
    assign cs_ok = (attr_pick[7:4] == 4'h0) && ($countones(~attr_pick[3:0]) == 1);

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_win <= '0;
            rsp_attr <= '0; rsp_perm <= '0; rsp_cs_n <= 4'hF;
        end else begin
            rsp_hit  <= req_valid && any_hit;
            rsp_miss <= req_valid && !any_hit;
            rsp_win  <= (req_valid && any_hit) ? pick : '0;
            rsp_attr <= (req_valid && any_hit) ? attr_pick : 8'h00;
            rsp_perm <= (req_valid && any_hit) ? win_perm[pick] : 2'b00;
            rsp_cs_n <= (req_valid && any_hit && cs_ok) ? attr_pick[3:0] : 4'hF;
        end
    end
endmodule

// File: rtl/addrwin_decoder.sv
// Top level: register file, comparators and priority response stage.
// Assumes 1 <= NUM_WIN <= 8.
module addrwin_decoder
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              snap_save,
    input  logic              snap_restore,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [7:0]        rsp_attr,
    output logic [1:0]        rsp_perm,
    output logic [3:0]        rsp_cs_n
);
    logic [NUM_WIN-1:0]       win_en;
    logic [NUM_WIN-1:0][1:0]  win_perm;
    logic [NUM_WIN-1:0][15:0] win_base;
    logic [NUM_WIN-1:0][7:0]  win_attr;
    logic [NUM_WIN-1:0][15:0] win_mask;
    logic [NUM_WIN-1:0]       hit_vec;

    addrwin_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .save(snap_save), .restore(snap_restore),
        .win_en(win_en), .win_perm(win_perm), .win_base(win_base),
        .win_attr(win_attr), .win_mask(win_mask)
    );

    addrwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr(req_addr), .win_en(win_en), .win_base(win_base),
        .win_mask(win_mask), .hit_vec(hit_vec)
    );

    addrwin_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit_vec(hit_vec),
        .win_perm(win_perm), .win_attr(win_attr),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
        .rsp_attr(rsp_attr), .rsp_perm(rsp_perm), .rsp_cs_n(rsp_cs_n)
    );
endmodule

// File: rtl/addrwin_checker.sv
// Protocol checks on the decoder's response ports; attached by bind below.
// Assumes the response is registered one cycle after the request.
module addrwin_checker #(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [IDX_W-1:0] rsp_win,
    input logic [7:0]       rsp_attr,
    input logic [1:0]       rsp_perm,
    input logic [3:0]       rsp_cs_n
);
    // R6: hit and miss are exclusive.
    assert_hit_miss_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));
    // R6: a miss carries zero code, zero permission and no chip select.
    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_attr == 8'h00 && rsp_perm == 2'b00 && rsp_cs_n == 4'hF));
    // R7: at most one chip select is driven low.
    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rsp_cs_n));
    // R7: a driven chip select comes from a memory target code on a hit.
    assert_cs_from_attr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_cs_n != 4'hF) |-> (rsp_hit && rsp_attr[7:4] == 4'h0 && rsp_attr[3:0] == rsp_cs_n));
    // R8: a valid request always yields a hit or miss next cycle.
    assert_resp_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit || rsp_miss));
    // R8: no request, no response.
    assert_no_req_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_hit && !rsp_miss));
    // R5: the winning index names an existing window.
    assert_win_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (int'(rsp_win) < NUM_WIN));
endmodule

bind addrwin_decoder addrwin_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_attr(rsp_attr),
    .rsp_perm(rsp_perm), .rsp_cs_n(rsp_cs_n)
);

// File: tb/sim_addrwin_decoder.sv
// Bench: behavioural reference model updated at each posedge, compared at each negedge.
module sim_addrwin_decoder;
    localparam int NW = 5;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic snap_save = 1'b0, snap_restore = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic rsp_hit, rsp_miss;
    logic [2:0] rsp_win;
    logic [7:0] rsp_attr;
    logic [1:0] rsp_perm;
    logic [3:0] rsp_cs_n;

    always #4 clk = ~clk;

    addrwin_decoder #(.NUM_WIN(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .snap_save(snap_save),
        .snap_restore(snap_restore), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
        .rsp_attr(rsp_attr), .rsp_perm(rsp_perm), .rsp_cs_n(rsp_cs_n)
    );

    int n_chk = 0, n_err = 0;
    string phase = "R1 reset";
    bit armed = 0;
    bit [31:0] m_ctrl, m_ovrd, s_ctrl;
    bit [31:0] m_base[8], m_mask[8], s_base[8], s_mask[8];
    bit e_hit, e_miss;
    int e_win;
    bit [7:0] e_attr;
    bit [1:0] e_perm;
    bit [3:0] e_cs;

    function automatic bit [31:0] mread(bit [4:0] a);
        int ix = a[2:0];
        if (a == 5'h00) return m_ctrl;
        if (a == 5'h01) return m_ovrd;
        if (a[4:3] == 2'd1 && ix < NW) return m_base[ix];
        if (a[4:3] == 2'd2 && ix < NW) return m_mask[ix];
        return 32'h0;
    endfunction

    function automatic string rtag(bit [4:0] a);
        if (a == 5'h00) return "R2";
        if (a == 5'h01) return "R10";
        return "R3";
    endfunction

    // Reference model: respond from pre-edge state, then apply register updates.
    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            m_ctrl = 0; m_ovrd = 0; s_ctrl = 0;
            for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_mask[i] = 0; s_base[i] = 0; s_mask[i] = 0; end
            e_hit = 0; e_miss = 0; e_win = 0; e_attr = 0; e_perm = 0; e_cs = 4'hF;
        end else begin
            e_hit = 0; e_miss = 0; e_win = 0; e_attr = 0; e_perm = 0; e_cs = 4'hF;
            if (req_valid) begin
                for (int i = 0; i < NW; i++) begin
                    if (!e_hit && m_ctrl[i] &&
                        (((req_addr[31:16] ^ m_base[i][31:16]) & ~m_mask[i][31:16]) == 0)) begin
                        e_hit = 1; e_win = i; e_attr = m_base[i][15:8];
                        e_perm = m_ctrl[16+2*i +: 2];
                    end
                end
                e_miss = !e_hit;
                if (e_hit && e_attr[7:4] == 0 &&
                    (e_attr[3:0] == 4'hE || e_attr[3:0] == 4'hD ||
                     e_attr[3:0] == 4'hB || e_attr[3:0] == 4'h7))
                    e_cs = e_attr[3:0];
            end
            if (snap_restore) begin
                m_ctrl = s_ctrl;
                for (int i = 0; i < 8; i++) begin m_base[i] = s_base[i]; m_mask[i] = s_mask[i]; end
            end else begin
                if (snap_save) begin
                    s_ctrl = m_ctrl;
                    for (int i = 0; i < 8; i++) begin s_base[i] = m_base[i]; s_mask[i] = m_mask[i]; end
                end
                if (cfg_we) begin
                    if (cfg_addr == 5'h00) m_ctrl = cfg_wdata & 32'h03FF_001F;
                    else if (cfg_addr == 5'h01) m_ovrd = cfg_wdata;
                    else if (cfg_addr[4:3] == 2'd1 && cfg_addr[2:0] < NW)
                        m_base[cfg_addr[2:0]] = cfg_wdata & 32'hFFFF_FF00;
                    else if (cfg_addr[4:3] == 2'd2 && cfg_addr[2:0] < NW)
                        m_mask[cfg_addr[2:0]] = cfg_wdata & 32'hFFFF_0000;
                end
            end
        end
    end

    task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    // Compare every output once per cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            cmp("R4 hit", 32'(rsp_hit), 32'(e_hit));
            cmp("R6 miss", 32'(rsp_miss), 32'(e_miss));
            cmp("R5 win", 32'(rsp_win), 32'(e_win));
            cmp("R3 attr", 32'(rsp_attr), 32'(e_attr));
            cmp("R2 perm", 32'(rsp_perm), 32'(e_perm));
            cmp("R7 cs_n", 32'(rsp_cs_n), 32'(e_cs));
            cmp({rtag(cfg_addr), " rdata"}, cfg_rdata, mread(cfg_addr));
        end
    end

    task automatic drive(bit we, bit [4:0] a, bit [31:0] d, bit sv, bit rs, bit rv, bit [31:0] ra);
        @(negedge clk); #1;
        cfg_we = we; cfg_addr = a; cfg_wdata = d; snap_save = sv;
        snap_restore = rs; req_valid = rv; req_addr = ra;
    endtask

    task automatic wr(bit [4:0] a, bit [31:0] d);
        drive(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic look(bit [31:0] ra, bit [4:0] a);
        drive(0, a, 0, 0, 0, 1, ra);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        phase = "R1 reset readback";
        for (int a = 0; a < 32; a++) look(32'h0000_1000 * a, 5'(a));
        phase = "R2 R3 programming";
        wr(5'h08, 32'h0000_0E00);
        wr(5'h10, 32'h0FFF_0000);
        wr(5'h09, 32'h1000_0DAB);
        wr(5'h11, 32'h0FFF_FFFF);
        wr(5'h0A, 32'h2000_0700);
        wr(5'h12, 32'h0FFF_0000);
        wr(5'h0B, 32'h4000_1E00);
        wr(5'h13, 32'h03FF_0000);
        wr(5'h0D, 32'hFFFF_FFFF);
        wr(5'h00, 32'hFC7F_FFEF);
        for (int a = 0; a < 24; a++) look(32'h0, 5'(a));
        phase = "R4 R7 lookups";
        look(32'h0000_0000, 5'h00); look(32'h0FFF_FFFF, 5'h08);
        look(32'h1234_5678, 5'h09); look(32'h2ABC_0000, 5'h0A);
        look(32'h3000_0000, 5'h0B); look(32'h43FF_FFFF, 5'h0B);
        look(32'h4400_0000, 5'h13); look(32'hF000_0000, 5'h00);
        drive(0, 5'h00, 0, 0, 0, 0, 32'h0000_0000);
        phase = "R8 idle";
        drive(0, 5'h00, 0, 0, 0, 0, 32'h1000_0000);
        phase = "R5 overlap";
        wr(5'h0C, 32'h0000_0300);
        wr(5'h14, 32'hFFFF_0000);
        wr(5'h00, 32'h0100_FFFF);
        look(32'h0800_0000, 5'h00); look(32'h3000_0000, 5'h0C);
        look(32'h4000_0000, 5'h14); look(32'hFFFF_FFFF, 5'h00);
        phase = "R11 write with request";
        drive(1, 5'h00, 32'h0000_0010, 0, 0, 1, 32'h0800_0000);
        look(32'h0800_0000, 5'h00);
        phase = "R9 save restore";
        drive(1, 5'h08, 32'h5500_0B00, 1, 0, 1, 32'h0000_0000);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0000_0000);
        look(32'h5500_0000, 5'h08);
        drive(1, 5'h09, 32'hAAAA_AAAA, 0, 1, 1, 32'h5500_0000);
        for (int a = 0; a < 24; a++) look(32'h0800_0000, 5'(a));
        phase = "R10 override";
        wr(5'h01, 32'hDEAD_BEEF);
        look(32'h1000_0000, 5'h01);
        look(32'hF000_0000, 5'h01);
        wr(5'h01, 32'h0000_0000);
        look(32'h1000_0000, 5'h01);
        phase = "R1 R2 R3 R4 R5 R9 R11 random";
        for (int k = 0; k < 600; k++) begin
            bit [31:0] ra = {3'($urandom_range(0, 5)), 29'($urandom)};
            bit [4:0] a = 5'($urandom);
            bit [31:0] d = $urandom;
            if (a[4:3] == 2'd2 && d[0]) d[31:28] = 4'h0;
            drive($urandom_range(0, 2) == 0, a, d, $urandom_range(0, 15) == 0,
                  $urandom_range(0, 15) == 0, $urandom_range(0, 3) != 0, ra);
        end
        phase = "R1 reset again";
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1 rst_n = 1'b1;
        look(32'h0000_0000, 5'h00);
        look(32'h0000_0000, 5'h08);
        @(negedge clk); @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog [%s] actual=running expected=finished", phase);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule